// File: doc/BRIEF.md
# Sequential Binary Spin Relaxer

This block stores a vector of binary spins, each meaning +1 or -1, and a full matrix of one-bit couplings, each also meaning +1 or -1. After a start it relaxes the spin vector towards a local energy minimum. It visits the spins strictly one at a time, in index order from 0 to N-1. At each visit it sets the spin to the sign of its local field: the sum over the other spins of coupling times spin. A full pass over all indices is a sweep.

The local field is built serially, one coupling bit per cycle, and the spin is written straight back. Later visits in the same sweep therefore see every earlier change. The run stops after the first sweep in which no spin changed, which is convergence. It also stops when a configured sweep limit is reached. For a given matrix and starting vector the outcome is fully deterministic.

Software loads the matrix and the starting vector through simple write ports while the block is idle. It pulses start, waits for done, and then reads the spin vector, the sweep count and the converged flag.

Top module: `spin_sweeper`

## Requirements
- R1: After reset all spin bits and all coupling bits are 0 (meaning -1), and busy, done, converged and sweepCount are all 0.
- R2: While idle, a cycle with spinWrEn high writes spinWrBit into spin spinWrIdx, where bit value 1 means +1 and 0 means -1. A cycle with cplWrEn high writes cplBit into the coupling used by spin cplRow for neighbour cplCol, with the same encoding. The written spin is visible on spinVec (bit i is spin i) on the next cycle.
- R3: While busy, spin writes, coupling writes and start pulses have no effect on the run or its result.
- R4: The local field of spin i is the sum over all j not equal to i of J[i][j]*s[j]. The diagonal coupling J[i][i] never matters. A positive field sets the spin to +1 and a negative field sets it to -1.
- R5: A local field of exactly zero leaves the spin at its current value.
- R6: Within a sweep the spins are updated in order 0 to N-1, each using the values already written earlier in the same sweep. At most one spin bit changes per cycle while busy.
- R7: Each spin visit takes N+1 cycles, so a sweep takes N*(N+1) cycles. done rises exactly S*N*(N+1) cycles after the clock edge that accepts start, where S is the number of sweeps run.
- R8: The run ends after the first sweep in which no spin changed. converged is then 1, sweepCount counts all sweeps including that quiet one, and every spin then agrees with the sign of its field or has a zero field.
- R9: If MAX_SWEEPS sweeps complete and each had a change, the run ends with converged at 0 and sweepCount equal to MAX_SWEEPS.
- R10: done and converged hold their values until the next accepted start, which clears both; done is never high while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| cplWrEn | input | 1 | Coupling write strobe |
| cplRow | input | IDX_W | Spin whose coupling is written |
| cplCol | input | IDX_W | Neighbour index of the coupling |
| cplBit | input | 1 | Coupling value, 1 = +1, 0 = -1 |
| spinWrEn | input | 1 | Spin write strobe |
| spinWrIdx | input | IDX_W | Spin index to write |
| spinWrBit | input | 1 | Spin value, 1 = +1, 0 = -1 |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| converged | output | 1 | Last run ended on a quiet sweep |
| sweepCount | output | SWEEP_W | Sweeps completed in the current or last run |
| spinVec | output | N_SPINS | Spin vector, bit i = spin i |

## Verification
Two couplings fill the whole matrix with one value each. A ferromagnetic matrix (all +1) and an antiferromagnetic one (all -1) separate a sign error in the field from a working majority rule. Matrices and starting vectors from a pseudo-random generator, with random diagonal bits, expose ordering mistakes, such as reading stale spins instead of values written in the same sweep, and any leak of the diagonal term. Balanced starting vectors create zero fields and show whether a tie keeps the spin or forces it. A second instance limited to a single sweep makes the first-sweep state visible and exercises the limit path. One run also pokes the write ports and start mid-run to show they are ignored.

// File: rtl/spin_sweeper_pkg.sv
package spin_sweeper_pkg;

  // Strobes sent by the sequencer to the datapath each cycle.
  typedef struct packed {
    logic clrField;  // zero the field accumulator
    logic accum;     // add one neighbour term
    logic apply;     // write the sign of the field into the current spin
  } dpStrobe_t;

endpackage

// File: rtl/spin_sweeper_dp.sv
module spin_sweeper_dp
  import spin_sweeper_pkg::*;
#(
  parameter int N_SPINS = 7,
  parameter int IDX_W   = 3,
  parameter int FIELD_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strb,
  input  logic [IDX_W-1:0]   rowIdx,
  input  logic [IDX_W-1:0]   colIdx,
  input  logic               loadOk,
  input  logic               cplWrEn,
  input  logic [IDX_W-1:0]   cplRow,
  input  logic [IDX_W-1:0]   cplCol,
  input  logic               cplBit,
  input  logic               spinWrEn,
  input  logic [IDX_W-1:0]   spinWrIdx,
  input  logic               spinWrBit,
  output logic               flipped,
  output logic [N_SPINS-1:0] spinVec
);

  localparam logic signed [FIELD_W-1:0] PLUS_ONE  = FIELD_W'(1);
  localparam logic signed [FIELD_W-1:0] MINUS_ONE = -FIELD_W'(1);

  logic [N_SPINS-1:0][N_SPINS-1:0] cplMem;
  logic [N_SPINS-1:0]              spinQ;
  logic signed [FIELD_W-1:0]       field;

  logic agree, selfTerm, fieldPos, fieldNeg, newBit;

  // Product of coupling and neighbour spin is +1 when the bits agree.
  assign agree    = ~(cplMem[rowIdx][colIdx] ^ spinQ[colIdx]);
  assign selfTerm = (colIdx == rowIdx);
  assign fieldNeg = field[FIELD_W-1];
  assign fieldPos = !fieldNeg && (field != '0);
  assign newBit   = fieldPos ? 1'b1 : (fieldNeg ? 1'b0 : spinQ[rowIdx]);
  assign flipped  = strb.apply && (newBit != spinQ[rowIdx]);
  assign spinVec  = spinQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      field <= '0;
    end else if (strb.clrField) begin
      field <= '0;
    end else if (strb.accum && !selfTerm) begin
      field <= field + (agree ? PLUS_ONE : MINUS_ONE);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spinQ <= '0;
    end else if (strb.apply) begin
      spinQ[rowIdx] <= newBit;
    end else if (loadOk && spinWrEn && (int'(spinWrIdx) < N_SPINS)) begin
      spinQ[spinWrIdx] <= spinWrBit;
    end
  end

  generate
    for (genvar r = 0; r < N_SPINS; r++) begin : g_row
      always_ff @(posedge clk) begin
        if (!rstN) begin
          cplMem[r] <= '0;
        end else if (loadOk && cplWrEn && (int'(cplRow) == r)
                     && (int'(cplCol) < N_SPINS)) begin
          cplMem[r][cplCol] <= cplBit;
        end
      end
    end
  endgenerate

  // R5
  tie_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.apply && field == '0) |=> spinQ[$past(rowIdx)] == $past(spinQ[rowIdx]));

  // R4
  sign_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.apply && field != '0) |=> spinQ[$past(rowIdx)] == !$past(fieldNeg));

  // R6
  single_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadOk |=> $countones(spinQ ^ $past(spinQ)) <= 1);

  // R3
  cpl_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadOk |=> $stable(cplMem));

endmodule

// File: rtl/spin_sweeper_ctrl.sv
module spin_sweeper_ctrl
  import spin_sweeper_pkg::*;
#(
  parameter int N_SPINS    = 7,
  parameter int MAX_SWEEPS = 16,
  parameter int IDX_W      = 3,
  parameter int SWEEP_W    = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               flipped,
  output dpStrobe_t          strb,
  output logic [IDX_W-1:0]   rowIdx,
  output logic [IDX_W-1:0]   colIdx,
  output logic               loadOk,
  output logic               busy,
  output logic               done,
  output logic               converged,
  output logic [SWEEP_W-1:0] sweepCount
);

  typedef enum logic [1:0] {S_IDLE, S_ACCUM, S_APPLY} seqState_t;

  localparam logic [IDX_W-1:0]   LAST_IDX  = IDX_W'(N_SPINS - 1);
  localparam logic [SWEEP_W-1:0] SWEEP_MAX = SWEEP_W'(MAX_SWEEPS);

  seqState_t state;
  logic      sweepFlip;
  logic      quietSweep;

  assign quietSweep    = !(sweepFlip || flipped);
  assign strb.accum    = (state == S_ACCUM);
  assign strb.apply    = (state == S_APPLY);
  assign strb.clrField = (state != S_ACCUM);
  assign busy          = (state != S_IDLE);
  assign loadOk        = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      rowIdx     <= '0;
      colIdx     <= '0;
      sweepCount <= '0;
      sweepFlip  <= 1'b0;
      done       <= 1'b0;
      converged  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start) begin
            state      <= S_ACCUM;
            rowIdx     <= '0;
            colIdx     <= '0;
            sweepCount <= '0;
            sweepFlip  <= 1'b0;
            done       <= 1'b0;
            converged  <= 1'b0;
          end
        end
        S_ACCUM: begin
          if (colIdx == LAST_IDX) begin
            colIdx <= '0;
            state  <= S_APPLY;
          end else begin
            colIdx <= colIdx + IDX_W'(1);
          end
        end
        S_APPLY: begin
          if (rowIdx == LAST_IDX) begin
            sweepCount <= sweepCount + SWEEP_W'(1);
            rowIdx     <= '0;
            sweepFlip  <= 1'b0;
            if (quietSweep) begin
              state     <= S_IDLE;
              done      <= 1'b1;
              converged <= 1'b1;
            end else if (sweepCount + SWEEP_W'(1) == SWEEP_MAX) begin
              state     <= S_IDLE;
              done      <= 1'b1;
              converged <= 1'b0;
            end else begin
              state <= S_ACCUM;
            end
          end else begin
            rowIdx    <= rowIdx + IDX_W'(1);
            sweepFlip <= sweepFlip | flipped;
            state     <= S_ACCUM;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // R8
  conv_implies_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    converged |-> done);

  // R9
  sweep_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    sweepCount <= SWEEP_MAX);

  // R7
  apply_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.apply |=> !strb.apply);

  // R6
  apply_after_accum_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.apply |-> $past(strb.accum) && $past(colIdx) == LAST_IDX);

endmodule

// File: rtl/spin_sweeper.sv
module spin_sweeper
  import spin_sweeper_pkg::*;
#(
  parameter int N_SPINS    = 7,
  parameter int MAX_SWEEPS = 16,
  localparam int IDX_W     = (N_SPINS > 1) ? $clog2(N_SPINS) : 1,
  localparam int SWEEP_W   = $clog2(MAX_SWEEPS + 1),
  localparam int FIELD_W   = $clog2(N_SPINS + 1) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               cplWrEn,
  input  logic [IDX_W-1:0]   cplRow,
  input  logic [IDX_W-1:0]   cplCol,
  input  logic               cplBit,
  input  logic               spinWrEn,
  input  logic [IDX_W-1:0]   spinWrIdx,
  input  logic               spinWrBit,
  output logic               busy,
  output logic               done,
  output logic               converged,
  output logic [SWEEP_W-1:0] sweepCount,
  output logic [N_SPINS-1:0] spinVec
);

  dpStrobe_t        strb;
  logic [IDX_W-1:0] rowIdx;
  logic [IDX_W-1:0] colIdx;
  logic             loadOk;
  logic             flipped;

  spin_sweeper_ctrl #(
    .N_SPINS(N_SPINS), .MAX_SWEEPS(MAX_SWEEPS),
    .IDX_W(IDX_W), .SWEEP_W(SWEEP_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .flipped(flipped),
    .strb(strb), .rowIdx(rowIdx), .colIdx(colIdx), .loadOk(loadOk),
    .busy(busy), .done(done), .converged(converged), .sweepCount(sweepCount)
  );

  spin_sweeper_dp #(
    .N_SPINS(N_SPINS), .IDX_W(IDX_W), .FIELD_W(FIELD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rowIdx(rowIdx), .colIdx(colIdx),
    .loadOk(loadOk), .cplWrEn(cplWrEn), .cplRow(cplRow), .cplCol(cplCol),
    .cplBit(cplBit), .spinWrEn(spinWrEn), .spinWrIdx(spinWrIdx),
    .spinWrBit(spinWrBit), .flipped(flipped), .spinVec(spinVec)
  );

endmodule

// File: tb/spin_sweeper_bench.sv
`timescale 1ns/1ps
module spin_sweeper_bench;

  localparam int N      = 7;
  localparam int MAXS   = 16;
  localparam int IW     = 3;
  localparam int SW     = 5;
  localparam int SWL    = 1;
  localparam int SWEEPC = N * (N + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic cplWrEn = 1'b0, cplBit = 1'b0, spinWrEn = 1'b0, spinWrBit = 1'b0;
  logic [IW-1:0] cplRow = '0, cplCol = '0, spinWrIdx = '0;

  logic busy, done, converged;
  logic [SW-1:0] sweepCount;
  logic [N-1:0] spinVec;
  logic busyL, doneL, convL;
  logic [SWL-1:0] sweepL;
  logic [N-1:0] spinL;

  int errors = 0;
  int checks = 0;
  logic [N-1:0][N-1:0] jm;
  logic [N-1:0] sm;
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;  // 125 MHz

  spin_sweeper #(.N_SPINS(N), .MAX_SWEEPS(MAXS)) u_spin_sweeper (
    .clk(clk), .rstN(rstN), .start(start), .cplWrEn(cplWrEn), .cplRow(cplRow),
    .cplCol(cplCol), .cplBit(cplBit), .spinWrEn(spinWrEn), .spinWrIdx(spinWrIdx),
    .spinWrBit(spinWrBit), .busy(busy), .done(done), .converged(converged),
    .sweepCount(sweepCount), .spinVec(spinVec));

  spin_sweeper #(.N_SPINS(N), .MAX_SWEEPS(1)) u_spin_sweeper_lim (
    .clk(clk), .rstN(rstN), .start(start), .cplWrEn(cplWrEn), .cplRow(cplRow),
    .cplCol(cplCol), .cplBit(cplBit), .spinWrEn(spinWrEn), .spinWrIdx(spinWrIdx),
    .spinWrBit(spinWrBit), .busy(busyL), .done(doneL), .converged(convL),
    .sweepCount(sweepL), .spinVec(spinL));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  function automatic int fieldOf(input logic [N-1:0][N-1:0] j, input logic [N-1:0] s,
                                 input int i);
    int f = 0;
    for (int k = 0; k < N; k++)
      if (k != i) f += (j[i][k] == s[k]) ? 1 : -1;
    return f;
  endfunction

  task automatic model(input logic [N-1:0][N-1:0] j, input logic [N-1:0] s0,
                       input int maxS, output logic [N-1:0] sf, output int sweeps,
                       output bit conv);
    logic [N-1:0] s = s0;
    sweeps = 0;
    conv = 0;
    while (1) begin
      int flips = 0;
      for (int i = 0; i < N; i++) begin
        int f = fieldOf(j, s, i);
        logic nb = (f > 0) ? 1'b1 : ((f < 0) ? 1'b0 : s[i]);
        if (nb != s[i]) flips++;
        s[i] = nb;
      end
      sweeps++;
      if (flips == 0) begin conv = 1; break; end
      if (sweeps == maxS) break;
    end
    sf = s;
  endtask

  task automatic loadAll(input logic [N-1:0][N-1:0] j, input logic [N-1:0] s);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        @(negedge clk);
        cplWrEn = 1'b1; cplRow = IW'(r); cplCol = IW'(c); cplBit = j[r][c];
      end
    @(negedge clk);
    cplWrEn = 1'b0;
    for (int i = 0; i < N; i++) begin
      spinWrEn = 1'b1; spinWrIdx = IW'(i); spinWrBit = s[i];
      @(negedge clk);
    end
    spinWrEn = 1'b0;
    @(negedge clk);
    jm = j;
    sm = s;
    check(spinVec == s, "R2 loaded spin vector", 32'(spinVec), 32'(s));
  endtask

  task automatic runCase(input string name, input bit poke);
    logic [N-1:0] expS, expSL;
    int expSw, expSwL, cnt;
    bit expC, expCL;
    model(jm, sm, MAXS, expS, expSw, expC);
    model(jm, sm, 1, expSL, expSwL, expCL);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 20000) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 3) begin
        start = 1'b1;
        spinWrEn = 1'b1; spinWrIdx = '0; spinWrBit = ~sm[0];
        cplWrEn = 1'b1; cplRow = IW'(1); cplCol = '0; cplBit = ~jm[1][0];
      end else if (poke && cnt == 4) begin
        start = 1'b0; spinWrEn = 1'b0; cplWrEn = 1'b0;
      end
    end
    if (!done) begin
      check(1'b0, {"R7 watchdog ", name}, 32'(cnt), 32'(expSw * SWEEPC));
      return;
    end
    $display("case %s: sweeps=%0d converged=%0d", name, expSw, expC);
    check(cnt == expSw * SWEEPC, {"R7 cycles to done ", name}, 32'(cnt), 32'(expSw * SWEEPC));
    check(spinVec == expS, {"R6 final spins ", name}, 32'(spinVec), 32'(expS));
    check(int'(sweepCount) == expSw, {"R8 sweep count ", name}, 32'(sweepCount), 32'(expSw));
    check(converged == expC, {"R8 converged flag ", name}, 32'(converged), 32'(expC));
    check(!busy, {"R10 idle at done ", name}, 32'(busy), 32'd0);
    check(spinL == expSL, {"R9 one-sweep spins ", name}, 32'(spinL), 32'(expSL));
    check(convL == expCL && int'(sweepL) == expSwL && doneL,
          {"R9 one-sweep status ", name}, {30'd0, convL, sweepL}, 32'({expCL, 1'(expSwL)}));
    if (expC) begin
      bit stable = 1;
      for (int i = 0; i < N; i++) begin
        int f = fieldOf(jm, spinVec, i);
        if ((f > 0 && !spinVec[i]) || (f < 0 && spinVec[i])) stable = 0;
      end
      check(stable, {"R8 local minimum ", name}, 32'(spinVec), 32'(expS));
    end
  endtask

  initial begin
    logic [N-1:0][N-1:0] jt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(spinVec == '0, "R1 spins", 32'(spinVec), 32'd0);
    check(!busy && !done && !converged, "R1 flags", {29'd0, busy, done, converged}, 32'd0);
    check(sweepCount == '0, "R1 sweep count", 32'(sweepCount), 32'd0);

    // R4 ferromagnetic, R4 antiferromagnetic
    jt = '1;
    loadAll(jt, 7'b0101101);
    runCase("ferro", 0);
    jt = '0;
    loadAll(jt, 7'b1100110);
    runCase("antiferro", 0);

    // R5 balanced starts give zero fields
    jt = '1;
    loadAll(jt, 7'b0111000);
    runCase("tie_low", 0);
    loadAll(jt, 7'b0111001);
    runCase("tie_high", 0);

    // R4 R6 pseudo-random matrices with random diagonals
    for (int t = 0; t < 10; t++) begin
      for (int r = 0; r < N; r++) jt[r] = N'(nextRand());
      loadAll(jt, N'(nextRand()));
      runCase($sformatf("rand%0d", t), 0);
    end

    // R10 done held while idle
    repeat (5) @(negedge clk);
    check(done, "R10 done held", 32'(done), 32'd1);

    // R3 writes and start ignored mid-run
    for (int r = 0; r < N; r++) jt[r] = N'(nextRand());
    loadAll(jt, N'(nextRand()));
    runCase("busy_poke", 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule